// File: doc/BRIEF.md
# Privilege Mode Selector and Alternate-Space Access Guard

This block keeps the processor's privilege state: a trap-level counter, a supervisor bit and a hypervisor-privileged bit. From these it produces a registered memory-access mode index. That index is what tells the translation path which set of mappings applies. An active trap level overrides both privilege bits and selects the nucleus mode.

The same state is used to guard loads and stores that name an alternate address space number. When such an access is strobed and the current privilege is not high enough, the block raises a privileged-action trap request in that same cycle.

A static strap says whether the core has a hypervisor. When the strap is low, the hypervisor-privileged bit has no effect on either the mode or the guard.

Top module: `priv_mode_gate`

## Requirements
- R1: Reset values. While `rstN` is low, the trap level loads `TL_MAX`, the supervisor bit loads 1, and the hypervisor-privileged bit loads the value of `hvFeature`. The mode index is nucleus (4) in the first cycle after reset.
- R2: If the trap level is non-zero, the mode index becomes nucleus (4), whatever the two privilege bits hold.
- R3: At trap level zero, the mode index is hypervisor (5) when `hvFeature` is 1 and the hypervisor-privileged bit is 1.
- R4: At trap level zero, when R3 does not apply, the mode index is kernel (2) if the supervisor bit is set and user (0) otherwise. When `hvFeature` is 0, the hypervisor-privileged bit is ignored.
- R5: The mode index is a register. It shows the state written at clock edge N only from edge N+1 onward.
- R6: A strobed access to a space number below 0x80 raises `privTrap` while the supervisor bit is clear.
- R7: When `hvFeature` is 1, a strobed access to a space number from 0x30 through 0x7F raises `privTrap` while the hypervisor-privileged bit is clear.
- R8: Only the low 8 bits of `asiNum` take part in the guard. Higher bits have no effect.
- R9: `privTrap` is combinational from the current state and is high only while `asiStrobe` is high.
- R10: `superTest` is high when the mode index is 2 or more. `hyperTest` is high only when the mode index is 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| hvFeature | input | 1 | Strap: the core has a hypervisor |
| tlWe | input | 1 | Write enable for the trap level |
| tlWdata | input | TL_W | New trap level |
| supWe | input | 1 | Write enable for the supervisor bit |
| supWdata | input | 1 | New supervisor bit |
| hvWe | input | 1 | Write enable for the hypervisor-privileged bit |
| hvWdata | input | 1 | New hypervisor-privileged bit |
| asiStrobe | input | 1 | An alternate-space access is requested this cycle |
| asiNum | input | ASI_W | Address space number of the access |
| modeIdx | output | 3 | Registered memory-access mode index |
| superTest | output | 1 | Mode is kernel level or above |
| hyperTest | output | 1 | Mode is hypervisor |
| privTrap | output | 1 | Privileged-action trap request |

## Verification
A state write and a guarded access can land in the same cycle. The guard judges the access against the state held before the edge. The new value then reaches the guard one edge before it reaches the mode index.

The bench provokes this by randomly pairing writes of the trap level and both privilege bits with strobed accesses. A bench model keeps the state and the delayed mode apart from each other. After each edge it checks that the trap follows the new state at once, while the mode index lags by one cycle.

// File: rtl/privmode_pkg.sv
package privmode_pkg;

  typedef enum logic [2:0] {
    MODE_USER       = 3'd0,
    MODE_USER_SEC   = 3'd1,
    MODE_KERNEL     = 3'd2,
    MODE_KERNEL_SEC = 3'd3,
    MODE_NUCLEUS    = 3'd4,
    MODE_HYPER      = 3'd5
  } accessMode_e;

  // Strobes the control half hands to the datapath half.
  typedef struct packed {
    logic tlActive;  // trap level is non-zero
    logic supOn;     // supervisor bit
    logic hvOn;      // hypervisor-privileged bit as stored
    logic hvFeat;    // hypervisor strap
  } privStrobes_t;

  localparam logic [7:0] ASI_PRIV_LIMIT = 8'h80;
  localparam logic [7:0] ASI_HV_LOW     = 8'h30;

endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import privmode_pkg::*;
#(
  parameter int TL_MAX = 6,
  parameter int TL_W   = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hvFeature,
  input  logic            tlWe,
  input  logic [TL_W-1:0] tlWdata,
  input  logic            supWe,
  input  logic            supWdata,
  input  logic            hvWe,
  input  logic            hvWdata,
  output privStrobes_t    strb
);

  localparam logic [TL_W-1:0] TL_RESET = TL_W'(TL_MAX);

  logic [TL_W-1:0] tlQ;
  logic            supQ;
  logic            hvQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tlQ  <= TL_RESET;
      supQ <= 1'b1;
      hvQ  <= hvFeature;
    end else begin
      if (tlWe)  tlQ  <= tlWdata;
      if (supWe) supQ <= supWdata;
      if (hvWe)  hvQ  <= hvWdata;
    end
  end

  always_comb begin
    strb.tlActive = (tlQ != '0);
    strb.supOn    = supQ;
    strb.hvOn     = hvQ;
    strb.hvFeat   = hvFeature;
  end

  // R1: the first cycle after reset shows the trap level at its maximum
  p_reset_tl_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> strb.tlActive);

  // R1: without the hypervisor strap, the bit comes out of reset clear
  p_reset_hv_r1: assert property (@(posedge clk)
    (!rstN && !hvFeature) |=> (!rstN || hvWe || !strb.hvOn || $past(hvWe)));

endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import privmode_pkg::*;
#(
  parameter int ASI_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  privStrobes_t     strb,
  input  logic             asiStrobe,
  input  logic [ASI_W-1:0] asiNum,
  output logic [2:0]       modeIdx,
  output logic             superTest,
  output logic             hyperTest,
  output logic             privTrap
);

  localparam logic [ASI_W-1:0] ASI_MASK = ASI_W'(8'hFF);

  accessMode_e     modeNext;
  accessMode_e     modeQ;
  logic [ASI_W-1:0] asiMasked;
  logic             asiLow;
  logic             asiHvBand;

  // Priority: trap level, then hypervisor, then supervisor, then user.
  always_comb begin
    if (strb.tlActive)                  modeNext = MODE_NUCLEUS;
    else if (strb.hvFeat && strb.hvOn)  modeNext = MODE_HYPER;
    else if (strb.supOn)                modeNext = MODE_KERNEL;
    else                                modeNext = MODE_USER;
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_NUCLEUS;
    else       modeQ <= modeNext;
  end

  assign modeIdx   = modeQ;
  assign superTest = (modeQ >= MODE_KERNEL);
  assign hyperTest = (modeQ == MODE_HYPER);

  // The guard looks at the low byte of the space number only.
  always_comb begin
    asiMasked = asiNum & ASI_MASK;
    asiLow    = (asiMasked < ASI_W'(ASI_PRIV_LIMIT));
    asiHvBand = (asiMasked >= ASI_W'(ASI_HV_LOW)) && asiLow;
    privTrap  = asiStrobe &&
                ((asiLow && !strb.supOn) ||
                 (strb.hvFeat && asiHvBand && !strb.hvOn));
  end

  // R2: an active trap level one cycle back yields nucleus
  p_nucleus_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.tlActive) |-> (modeIdx == 3'd4));

  // R4: with no hypervisor strap, the hypervisor mode never shows
  p_no_hyper_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.hvFeat && !$past(strb.hvFeat)) |-> (modeIdx != 3'd5));

  // R9: the trap request needs the access strobe
  p_trap_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    privTrap |-> asiStrobe);

  // R10: hypervisor mode always passes the supervisor test
  p_hyper_is_super_r10: assert property (@(posedge clk) disable iff (!rstN)
    hyperTest |-> superTest);

  // R1: the mode index only takes the four encodings the selector makes
  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modeIdx == 3'd0) || (modeIdx == 3'd2) || (modeIdx == 3'd4) || (modeIdx == 3'd5));

  // R6: the supervisor bit clear makes a low-numbered access trap
  p_low_traps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (asiStrobe && !strb.supOn && (asiNum[7:0] < 8'h80)) |-> privTrap);

endmodule

// File: rtl/priv_mode_gate.sv
module priv_mode_gate
  import privmode_pkg::*;
#(
  parameter int TL_MAX = 6,
  parameter int TL_W   = $clog2(TL_MAX + 1),
  parameter int ASI_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hvFeature,
  input  logic             tlWe,
  input  logic [TL_W-1:0]  tlWdata,
  input  logic             supWe,
  input  logic             supWdata,
  input  logic             hvWe,
  input  logic             hvWdata,
  input  logic             asiStrobe,
  input  logic [ASI_W-1:0] asiNum,
  output logic [2:0]       modeIdx,
  output logic             superTest,
  output logic             hyperTest,
  output logic             privTrap
);

  privStrobes_t strb;

  pm_ctrl #(.TL_MAX(TL_MAX), .TL_W(TL_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hvFeature(hvFeature),
    .tlWe     (tlWe),
    .tlWdata  (tlWdata),
    .supWe    (supWe),
    .supWdata (supWdata),
    .hvWe     (hvWe),
    .hvWdata  (hvWdata),
    .strb     (strb)
  );

  pm_datapath #(.ASI_W(ASI_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .asiStrobe(asiStrobe),
    .asiNum   (asiNum),
    .modeIdx  (modeIdx),
    .superTest(superTest),
    .hyperTest(hyperTest),
    .privTrap (privTrap)
  );

endmodule

// File: tb/priv_mode_gate_test.sv
module priv_mode_gate_test;

  localparam int CLK_PERIOD = 10;
  localparam int TL_MAX = 6;
  localparam int TL_W   = $clog2(TL_MAX + 1);
  localparam int ASI_W  = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hvFeature = 1'b0;
  logic tlWe = 1'b0;
  logic [TL_W-1:0] tlWdata = '0;
  logic supWe = 1'b0, supWdata = 1'b0, hvWe = 1'b0, hvWdata = 1'b0;
  logic asiStrobe = 1'b0;
  logic [ASI_W-1:0] asiNum = '0;
  logic [2:0] modeIdx;
  logic superTest, hyperTest, privTrap;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Bench model state
  int mTl;
  bit mSup, mHv;
  int mMode;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_mode_gate #(.TL_MAX(TL_MAX), .ASI_W(ASI_W)) uut (
    .clk(clk), .rstN(rstN), .hvFeature(hvFeature),
    .tlWe(tlWe), .tlWdata(tlWdata), .supWe(supWe), .supWdata(supWdata),
    .hvWe(hvWe), .hvWdata(hvWdata), .asiStrobe(asiStrobe), .asiNum(asiNum),
    .modeIdx(modeIdx), .superTest(superTest), .hyperTest(hyperTest),
    .privTrap(privTrap)
  );

  function automatic int expMode(int tl, bit sup, bit hv, bit feat);
    if (tl != 0) return 4;
    if (feat && hv) return 5;
    if (sup) return 2;
    return 0;
  endfunction

  function automatic bit expTrap(bit stb, int asi, bit sup, bit hv, bit feat);
    int low = asi & 8'hFF;
    if (!stb) return 1'b0;
    if (low < 8'h80 && !sup) return 1'b1;
    if (feat && low >= 8'h30 && low < 8'h80 && !hv) return 1'b1;
    return 1'b0;
  endfunction

  task automatic checkEq(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // One cycle: drive at negedge, check after settling, then advance the model.
  task automatic step(bit tWe, int tVal, bit sWe, bit sVal, bit hWe, bit hVal,
                      bit stb, int asi, string reqT);
    string reqM;
    @(negedge clk);
    tlWe = tWe; tlWdata = TL_W'(tVal);
    supWe = sWe; supWdata = sVal;
    hvWe = hWe; hvWdata = hVal;
    asiStrobe = stb; asiNum = ASI_W'(asi);
    #1;
    if (mMode == 4) reqM = "R2";
    else if (mMode == 5) reqM = "R3";
    else reqM = "R4";
    checkEq(reqM, "modeIdx", int'(modeIdx), mMode);
    checkEq("R10", "superTest", int'(superTest), int'(mMode >= 2));
    checkEq("R10", "hyperTest", int'(hyperTest), int'(mMode == 5));
    checkEq(reqT, "privTrap", int'(privTrap), int'(expTrap(stb, asi, mSup, mHv, hvFeature)));
    @(posedge clk);
    mMode = expMode(mTl, mSup, mHv, hvFeature);
    if (tWe) mTl = tVal;
    if (sWe) mSup = sVal;
    if (hWe) mHv = hVal;
  endtask

  task automatic doReset(bit feat);
    @(negedge clk);
    rstN = 1'b0; hvFeature = feat;
    tlWe = 0; supWe = 0; hvWe = 0; asiStrobe = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mTl = TL_MAX; mSup = 1'b1; mHv = feat; mMode = 4;
    #1;
    checkEq("R1", "modeIdx after reset", int'(modeIdx), 4);
    checkEq("R1", "privTrap after reset", int'(privTrap), 0);
  endtask

  task automatic runPhase(bit feat);
    doReset(feat);
    // R1: supervisor reset value is visible through an access
    step(0, 0, 0, 0, 0, 0, 1, 'h10, "R1");
    // R5: clear the trap level; the mode changes one edge later
    step(1, 0, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R1: the reset hypervisor bit is now shown in the mode
    step(0, 0, 0, 0, 0, 0, 1, 'h40, "R7");
    // Drop both privileges: user mode
    step(0, 0, 1, 0, 1, 0, 0, 0, "R9");
    // R6 at once on the new state; mode still lags (R5)
    step(0, 0, 0, 0, 0, 0, 1, 'h05, "R6");
    // R8: upper bits ignored, low byte 0x20 traps
    step(0, 0, 0, 0, 0, 0, 1, 'h120, "R8");
    // R8: low byte 0x90 does not trap even with upper bits set
    step(0, 0, 0, 0, 0, 0, 1, 'hF90, "R8");
    // R9: no strobe, no trap
    step(0, 0, 0, 0, 0, 0, 0, 'h10, "R9");
    // R7: supervisor on, hypervisor bit off, band edges
    step(0, 0, 1, 1, 0, 0, 1, 'h30, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 'h7F, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 'h2F, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 'h80, "R6");
    // R2: hypervisor bit set but trap level non-zero wins
    step(1, 3, 0, 0, 1, 1, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 1, 'h50, "R7");
    // Random mix of writes and strobed accesses
    for (int i = 0; i < 400; i++) begin
      bit tWe = ($urandom % 5) == 0;
      int tVal = (($urandom % 2) == 0) ? 0 : int'($urandom % (TL_MAX + 1));
      step(tWe, tVal, ($urandom % 4) == 0, 1'($urandom), ($urandom % 4) == 0, 1'($urandom),
           1'($urandom), int'($urandom % 4096), "R6");
    end
  endtask

  initial begin
    void'($urandom(32'd2468));
    runPhase(1'b0);
    runPhase(1'b1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule